// File: doc/BRIEF.md
# Watchdog Timer with Shared Prescaler

This block is a free-running watchdog counter that shares one prescaler with a general-purpose timer. The prescaler has one owner at a time, chosen by a select input. When the watchdog owns it, the watchdog counter advances once per prescaler wrap, so the timeout period grows with the programmed ratio. When the timer owns it, the prescaler divides the timer's count source and reports each wrap on a timer-side pulse output. In that case the watchdog counter advances on every base tick.

Software keeps the watchdog from expiring by issuing a clear strobe. The clear strobe zeroes the watchdog counter. It zeroes the prescaler only when the watchdog owns it. It also raises both status flags, time-out and power-down. A sleep strobe zeroes the counter, drops the power-down flag and raises the time-out flag. When the 8-bit counter wraps, the block emits a one-cycle reset pulse and drops the time-out flag. Oscillator detail is abstracted into a single base-tick input.

Top module: `wdt_shared_ps`

## Requirements
- R1: A clear strobe sets the watchdog counter to zero. After the clear, the next timeout needs a full 256 counter steps.
- R2: With the prescaler owned by the watchdog (`ps_to_wdog_i`=1), a clear strobe also sets the prescaler count to zero.
- R3: With the prescaler owned by the timer (`ps_to_wdog_i`=0), a clear strobe leaves the prescaler count unchanged.
- R4: On the edge that takes a clear strobe, the time-out flag `to_o` becomes 1 and the power-down flag `pd_o` becomes 1.
- R5: The prescaler wraps every R = 2^(`ps_sel_i`+1) steps, from 1:2 at `ps_sel_i`=0 up to 1:256 at `ps_sel_i`=7. With the watchdog owning the prescaler, the counter advances once per prescaler wrap, so a timeout comes after 256*R ticks. With the timer owning it, the counter advances on every tick, so a timeout comes after 256 ticks.
- R6: On counter wrap, `wdt_reset_o` is high for exactly one cycle and `to_o` reads 0 in that cycle. Counting restarts from zero, so the next timeout comes one full period later.
- R7: A sleep strobe (with no clear strobe in the same cycle) zeroes the counter and sets `pd_o`=0 and `to_o`=1.
- R8: While `wd_en_i` is 0, neither the watchdog counter nor a watchdog-owned prescaler advances.
- R9: After reset, `to_o`=1, `pd_o`=1 and `wdt_reset_o`=0, and the counter and prescaler are zero.
- R10: While the timer owns the prescaler, each `tmr_src_i` pulse is one prescaler step. `tmr_ps_tick_o` pulses for one cycle at every R-th step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| tick_i | input | 1 | Base watchdog tick, one cycle per tick |
| wd_en_i | input | 1 | Watchdog enable |
| clr_wd_i | input | 1 | Clear-watchdog strobe |
| sleep_i | input | 1 | Sleep-entry strobe |
| ps_to_wdog_i | input | 1 | Prescaler owner: 1 = watchdog, 0 = timer |
| ps_sel_i | input | 3 | Prescale select, ratio 2^(sel+1) |
| tmr_src_i | input | 1 | Timer count source, one cycle per step |
| wdt_reset_o | output | 1 | One-cycle watchdog timeout reset pulse |
| to_o | output | 1 | Time-out status flag |
| pd_o | output | 1 | Power-down status flag |
| tmr_ps_tick_o | output | 1 | Prescaler wrap pulse to the timer |

## Verification
A watchdog-owned prescaler wrap advances the counter on the same edge. Every result is therefore registered exactly once: a timeout is visible after the 256*R-th ticking edge, the flags after the edge that takes a strobe, and the timer pulse after the R-th source edge. The bench drives inputs on falling edges and samples on falling edges, counting them. The n-th sample after a drive therefore reflects exactly n rising edges. Each period check records the sample index of the first pulse and compares it with the arithmetic value 256*R (or the shortened value after a hold or a clear), so a one-step slip in either direction is reported.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int unsigned WD_CNT_W = 8;
    localparam int unsigned PS_CNT_W = 8;
    localparam int unsigned PS_SEL_W = 3;

    typedef enum logic {
        PS_OWNER_TIMER = 1'b0,
        PS_OWNER_WDOG  = 1'b1
    } ps_owner_e;

    typedef struct packed {
        logic time_out;
        logic power_down;
    } wdt_flags_t;

    // Last count before wrap for ratio 2^(sel+1)
    function automatic logic [PS_CNT_W-1:0] ps_last(input logic [PS_SEL_W-1:0] sel);
        logic [PS_CNT_W:0] ratio;
        ratio = {{PS_CNT_W{1'b0}}, 1'b1} << (int'(sel) + 1);
        return PS_CNT_W'(ratio - 1'b1);
    endfunction

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler
    import wdt_pkg::*;
#(
    parameter int unsigned CNT_W = PS_CNT_W,
    parameter int unsigned SEL_W = PS_SEL_W
) (
    input  logic             clk,
    input  logic             rst,
    input  ps_owner_e        owner,
    input  logic [SEL_W-1:0] sel,
    input  logic             wd_step,
    input  logic             tm_step,
    input  logic             wd_clear,
    output logic             wd_wrap,
    output logic             tm_wrap_q
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last;
    logic             step;
    logic             at_last;
    logic             own_wd;

    assign own_wd  = (owner == PS_OWNER_WDOG);
    assign last    = CNT_W'(ps_last(PS_SEL_W'(sel)));
    assign step    = own_wd ? wd_step : tm_step;
    assign at_last = (cnt_q >= last);
    assign wd_wrap = own_wd && wd_step && at_last && !wd_clear;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q     <= '0;
            tm_wrap_q <= 1'b0;
        end else begin
            tm_wrap_q <= !own_wd && tm_step && at_last;
            if (own_wd && wd_clear)
                cnt_q <= '0;
            else if (step)
                cnt_q <= at_last ? '0 : cnt_q + 1'b1;
        end
    end

    // R2: clear under watchdog ownership zeroes the prescaler
    p_clear_resets_ps_r2: assert property (@(posedge clk) disable iff (rst)
        (own_wd && wd_clear) |=> (cnt_q == '0));

    // R3: under timer ownership only timer steps move the prescaler
    p_timer_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!own_wd && !tm_step) |=> $stable(cnt_q));

    // R10: timer wrap pulse lasts one cycle for ratios of two or more
    p_tm_pulse_single_r10: assert property (@(posedge clk) disable iff (rst)
        tm_wrap_q |-> (cnt_q == '0));

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
    import wdt_pkg::*;
#(
    parameter int unsigned CNT_W = WD_CNT_W
) (
    input  logic clk,
    input  logic rst,
    input  logic adv,
    input  logic clear,
    output logic wrap
);

    logic [CNT_W-1:0] cnt_q;

    assign wrap = adv && !clear && (cnt_q == {CNT_W{1'b1}});

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (clear)
            cnt_q <= '0;
        else if (adv)
            cnt_q <= cnt_q + 1'b1;
    end

    // R1 / R7: clear or sleep zeroes the watchdog count
    p_clear_zero_r1: assert property (@(posedge clk) disable iff (rst)
        clear |=> (cnt_q == '0));

    // R8: no advance, no clear -> count holds
    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!adv && !clear) |=> $stable(cnt_q));

endmodule

// File: rtl/wdt_status.sv
module wdt_status
    import wdt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       sleep,
    input  logic       wrap,
    output wdt_flags_t flags_q,
    output logic       pulse_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '{time_out: 1'b1, power_down: 1'b1};
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= wrap;
            if (clr)
                flags_q <= '{time_out: 1'b1, power_down: 1'b1};
            else if (sleep)
                flags_q <= '{time_out: 1'b1, power_down: 1'b0};
            else if (wrap)
                flags_q.time_out <= 1'b0;
        end
    end

    // R4: clear sets both flags
    p_clear_flags_r4: assert property (@(posedge clk) disable iff (rst)
        clr |=> (flags_q.time_out && flags_q.power_down));

    // R7: sleep alone sets time-out, drops power-down
    p_sleep_flags_r7: assert property (@(posedge clk) disable iff (rst)
        (sleep && !clr) |=> (flags_q.time_out && !flags_q.power_down));

    // R6: timeout pulse shows time-out low and lasts one cycle
    p_pulse_to_low_r6: assert property (@(posedge clk) disable iff (rst)
        pulse_q |-> !flags_q.time_out);
    p_pulse_single_r6: assert property (@(posedge clk) disable iff (rst)
        pulse_q |=> !pulse_q);

endmodule

// File: rtl/wdt_shared_ps.sv
module wdt_shared_ps
    import wdt_pkg::*;
#(
    parameter int unsigned CNT_W = WD_CNT_W,
    parameter int unsigned PS_W  = PS_CNT_W,
    parameter int unsigned SEL_W = PS_SEL_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             wd_en_i,
    input  logic             clr_wd_i,
    input  logic             sleep_i,
    input  logic             ps_to_wdog_i,
    input  logic [SEL_W-1:0] ps_sel_i,
    input  logic             tmr_src_i,
    output logic             wdt_reset_o,
    output logic             to_o,
    output logic             pd_o,
    output logic             tmr_ps_tick_o
);

    ps_owner_e  owner;
    logic       wd_tick;
    logic       ps_wd_wrap;
    logic       cnt_adv;
    logic       cnt_clear;
    logic       cnt_wrap;
    wdt_flags_t flags;

    assign owner     = ps_owner_e'(ps_to_wdog_i);
    assign wd_tick   = tick_i && wd_en_i;
    assign cnt_adv   = (owner == PS_OWNER_WDOG) ? ps_wd_wrap : wd_tick;
    assign cnt_clear = clr_wd_i || sleep_i;

    wdt_prescaler #(.CNT_W(PS_W), .SEL_W(SEL_W)) u_ps (
        .clk       (clk),
        .rst       (rst),
        .owner     (owner),
        .sel       (ps_sel_i),
        .wd_step   (wd_tick),
        .tm_step   (tmr_src_i),
        .wd_clear  (clr_wd_i),
        .wd_wrap   (ps_wd_wrap),
        .tm_wrap_q (tmr_ps_tick_o)
    );

    wdt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .adv   (cnt_adv),
        .clear (cnt_clear),
        .wrap  (cnt_wrap)
    );

    wdt_status u_st (
        .clk     (clk),
        .rst     (rst),
        .clr     (clr_wd_i),
        .sleep   (sleep_i),
        .wrap    (cnt_wrap),
        .flags_q (flags),
        .pulse_q (wdt_reset_o)
    );

    assign to_o = flags.time_out;
    assign pd_o = flags.power_down;

    // R5: timer-owned prescaler never feeds the watchdog counter
    p_owner_route_r5: assert property (@(posedge clk) disable iff (rst)
        (!ps_to_wdog_i && !wd_tick) |=> !wdt_reset_o);

endmodule

// File: tb/sim_wdt_shared_ps.sv
module sim_wdt_shared_ps;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_i = 1'b0;
    logic       wd_en_i = 1'b1;
    logic       clr_wd_i = 1'b0;
    logic       sleep_i = 1'b0;
    logic       ps_to_wdog_i = 1'b1;
    logic [2:0] ps_sel_i = 3'd0;
    logic       tmr_src_i = 1'b0;
    logic       wdt_reset_o, to_o, pd_o, tmr_ps_tick_o;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    wdt_shared_ps u0 (
        .clk(clk), .rst(rst), .tick_i(tick_i), .wd_en_i(wd_en_i),
        .clr_wd_i(clr_wd_i), .sleep_i(sleep_i), .ps_to_wdog_i(ps_to_wdog_i),
        .ps_sel_i(ps_sel_i), .tmr_src_i(tmr_src_i), .wdt_reset_o(wdt_reset_o),
        .to_o(to_o), .pd_o(pd_o), .tmr_ps_tick_o(tmr_ps_tick_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; tick_i = 1'b0; clr_wd_i = 1'b0; sleep_i = 1'b0;
        tmr_src_i = 1'b0; wd_en_i = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // Count samples until the first timeout pulse; check index and flag
    task automatic run_to_pulse(input int exp, input string tag);
        int first = 0;
        int to_at = -1;
        for (int n = 1; n <= exp + 4; n++) begin
            @(negedge clk);
            if (wdt_reset_o && first == 0) begin
                first = n;
                to_at = int'(to_o);
            end
        end
        check({tag, " period"}, first, exp);
        check({tag, " to_o at pulse"}, to_at, 0);
    endtask

    initial begin
        // R9: reset state
        do_reset();
        @(negedge clk);
        check("R9 to_o", int'(to_o), 1);
        check("R9 pd_o", int'(pd_o), 1);
        check("R9 wdt_reset_o", int'(wdt_reset_o), 0);

        // R5 sweep: watchdog-owned prescaler, all ratios up to 1:128
        for (int s = 0; s < 7; s++) begin
            do_reset();
            ps_to_wdog_i = 1'b1; ps_sel_i = 3'(s); tick_i = 1'b1;
            run_to_pulse(256 * (2 << s), $sformatf("R5 sel=%0d", s));
            if (s < 2) begin
                // R6: pulse width one, restart from zero (4 samples already used)
                run_to_pulse(256 * (2 << s) - 4, $sformatf("R6 restart sel=%0d", s));
            end
        end

        // R4: clear after timeout raises both flags
        @(negedge clk);
        tick_i = 1'b0; clr_wd_i = 1'b1;
        @(negedge clk);
        clr_wd_i = 1'b0;
        check("R4 to_o after clear", int'(to_o), 1);
        check("R4 pd_o after clear", int'(pd_o), 1);

        // R5: timer-owned, counter steps on every tick
        do_reset();
        ps_to_wdog_i = 1'b0; ps_sel_i = 3'd5; tick_i = 1'b1;
        run_to_pulse(256, "R5 timer-owned");

        // R1 + R2: clear mid-count zeroes counter and prescaler (R=4)
        do_reset();
        ps_to_wdog_i = 1'b1; ps_sel_i = 3'd1; tick_i = 1'b1;
        repeat (43) @(negedge clk);
        tick_i = 1'b0; clr_wd_i = 1'b1;
        @(negedge clk);
        clr_wd_i = 1'b0; tick_i = 1'b1;
        run_to_pulse(1024, "R1 R2 clear mid-count");

        // R7: sleep zeroes counter, pd low, to high
        do_reset();
        ps_to_wdog_i = 1'b0; tick_i = 1'b1;
        repeat (100) @(negedge clk);
        tick_i = 1'b0; sleep_i = 1'b1;
        @(negedge clk);
        sleep_i = 1'b0;
        check("R7 pd_o after sleep", int'(pd_o), 0);
        check("R7 to_o after sleep", int'(to_o), 1);
        tick_i = 1'b1;
        run_to_pulse(256, "R7 counter after sleep");

        // R8: disable holds counter and prescaler (R=2)
        do_reset();
        ps_to_wdog_i = 1'b1; ps_sel_i = 3'd0; tick_i = 1'b1;
        repeat (101) @(negedge clk);
        wd_en_i = 1'b0;
        repeat (50) @(negedge clk);
        wd_en_i = 1'b1;
        run_to_pulse(512 - 101, "R8 enable hold");

        // R10: timer-owned prescaler divides timer source by 4
        do_reset();
        ps_to_wdog_i = 1'b0; ps_sel_i = 3'd1; tmr_src_i = 1'b1;
        for (int k = 1; k <= 4; k++) begin
            @(negedge clk);
            check($sformatf("R10 timer pulse step %0d", k), int'(tmr_ps_tick_o), (k == 4) ? 1 : 0);
        end
        // R3: three steps, clear, one step -> wrap (prescaler kept)
        repeat (3) @(negedge clk);
        tmr_src_i = 1'b0; clr_wd_i = 1'b1;
        @(negedge clk);
        check("R3 no pulse during clear", int'(tmr_ps_tick_o), 0);
        clr_wd_i = 1'b0; tmr_src_i = 1'b1;
        @(negedge clk);
        tmr_src_i = 1'b0;
        check("R3 prescaler kept across clear", int'(tmr_ps_tick_o), 1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (180000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule